// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Shared-Bus Processor

This block is a small processor core that executes one instruction at a time. Every value moves over a single 8-bit bus. It holds eight general registers, an operand latch A and a result latch B. B is loaded from an adder/subtractor that combines A with the current bus value. An instruction register and a two-bit step counter feed a hard-wired decoder, and that decoder produces every enable in each step.

The host presents an instruction word on `din` and pulses `run` while the core is idle. The word is captured on that clock edge, and execution begins in the next cycle. Moves and immediate loads take one step. Additions and subtractions take three steps. `done` is high during the final step. The core then returns to idle and waits for the next `run`. The bus value is visible on `bus`, so the host can read any register by issuing a move of that register onto itself.

Top module: `bus_cpu8`

## Requirements
- R1: A synchronous reset clears all eight registers and leaves the core idle. While idle, `done` is 0 and `bus` is 0.
- R2: The instruction word is captured from `din` only on an edge where `run` is 1 and the core is idle. A `run` pulse during execution, including during the `done` step, is ignored.
- R3: Opcode 10 in bits 7:6 is a load immediate. In the first cycle after capture, `din` drives the bus, register Rx (bits 5:3) is loaded from it, and `done` is 1.
- R4: Opcode 00 is a move. In the first cycle after capture, register Ry (bits 2:0) drives the bus, Rx is loaded from it, and `done` is 1.
- R5: Opcode 01 is an add. It takes three cycles. The bus shows Rx in the first cycle, Ry in the second, and the sum modulo 256 in the third. `done` is 1 only in the third cycle, and Rx receives the sum.
- R6: Opcode 11 is a subtract. It uses the same three-cycle sequence as R5, and the third cycle shows Rx − Ry modulo 256, which is written to Rx.
- R7: An instruction writes only the register addressed by bits 5:3. All other registers keep their values.
- R8: At most one source drives the bus in any cycle, and at most one register load strobe is active.
- R9: After the `done` cycle, the core is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Start request, taken only when idle |
| din | input | 8 | Instruction word, or immediate data during the load step |
| done | output | 1 | High in the last step of an instruction |
| bus | output | 8 | Value on the shared bus |

## Verification
An error in the step counter or in the opcode decode shows up at once as a wrong value on `bus` or as `done` appearing in the wrong cycle. Each step's bus value is compared in the cycle where that step occurs. A wrong register write cannot be seen until that register is next placed on the bus. For this reason, all eight registers are read back after every directed scenario, and the random sequence keeps reading operands through the bus against a reference array.

// File: rtl/bus_cpu8.sv
module bus_cpu8 #(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] din,
  output logic          done,
  output logic [DW-1:0] bus
);
  localparam int RW = $clog2(NREG);
  localparam int IW = 2 + 2*RW;

  logic [IW-1:0] ir;
  logic [1:0]    step;
  logic          busy;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] a_q, b_q, bus_w;

  logic [1:0]    op;
  logic [RW-1:0] fx, fy;
  logic          s0, s1, s2;
  logic          rx_out, ry_out, din_oe, b_oe, a_in, b_in, asub, rx_in;
  logic [NREG-1:0] dx, dy, reg_oe, reg_ld;

  assign op = ir[IW-1 -: 2];
  assign fx = ir[2*RW-1 -: RW];
  assign fy = ir[RW-1:0];

  assign s0 = busy & (step == 2'd0);
  assign s1 = busy & (step == 2'd1);
  assign s2 = busy & (step == 2'd2);

  assign rx_out = op[0] & s0;
  assign a_in   = op[0] & s0;
  assign ry_out = (~op[0] & ~op[1] & s0) | (op[0] & s1);
  assign din_oe = ~op[0] & op[1] & s0;
  assign b_in   = op[0] & s1;
  assign asub   = op[0] & op[1] & s1;
  assign b_oe   = op[0] & s2;
  assign rx_in  = (~op[0] & s0) | (op[0] & s2);
  assign done   = rx_in;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign dx[i]     = (fx == RW'(i));
    assign dy[i]     = (fy == RW'(i));
    assign reg_oe[i] = (rx_out & dx[i]) | (ry_out & dy[i]);
    assign reg_ld[i] = rx_in & dx[i];
    always_ff @(posedge clk) begin
      if (rst)            regs[i] <= '0;
      else if (reg_ld[i]) regs[i] <= bus_w;
    end
  end

  always_comb begin
    bus_w = '0;
    for (int i = 0; i < NREG; i++)
      if (reg_oe[i]) bus_w = bus_w | regs[i];
    if (din_oe) bus_w = bus_w | din;
    if (b_oe)   bus_w = bus_w | b_q;
  end

  assign bus = bus_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= 2'd0;
      ir   <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      if (!busy) begin
        step <= 2'd0;
        if (run) begin
          ir   <= din[IW-1:0];
          busy <= 1'b1;
        end
      end else if (done) begin
        busy <= 1'b0;
        step <= 2'd0;
      end else begin
        step <= step + 2'd1;
      end
      if (a_in) a_q <= bus_w;
      if (b_in) b_q <= asub ? a_q - bus_w : a_q + bus_w;
    end
  end
endmodule

// File: rtl/bus_cpu8_chk.sv
module bus_cpu8_chk #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  parameter int IW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic            busy,
  input logic [1:0]      step,
  input logic            done,
  input logic [IW-1:0]   ir,
  input logic [NREG+1:0] src,
  input logic [NREG-1:0] ld,
  input logic [DW-1:0]   bus
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) $onehot0(src)); // R8
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst) $onehot0(ld)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (bus == '0 && !done)); // R1
  AST_START: assert property (@(posedge clk) disable iff (rst) (!busy && run) |=> (busy && step == 2'd0)); // R2
  AST_IR_HELD: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(ir)); // R2
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst) busy |-> step <= 2'd2); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |=> !busy); // R9
endmodule

bind bus_cpu8 bus_cpu8_chk #(.DW(DW), .NREG(NREG), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .busy(busy), .step(step), .done(done),
  .ir(ir), .src({reg_oe, din_oe, b_oe}), .ld(reg_ld), .bus(bus)
);

// File: tb/sim_bus_cpu8.sv
`timescale 1ns/1ps
module sim_bus_cpu8;
  logic clk = 0, rst = 1, run = 0;
  logic [7:0] din = 0;
  logic done;
  logic [7:0] bus;
  int nchk = 0, nfail = 0;
  logic [7:0] m [8];

  bus_cpu8 u0 (.clk(clk), .rst(rst), .run(run), .din(din), .done(done), .bus(bus));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [7:0] ins, input logic [7:0] imm, input bit hold_run);
    logic [1:0] op = ins[7:6];
    int x = ins[5:3];
    int y = ins[2:0];
    logic [7:0] res;
    @(negedge clk); run = 1; din = ins;
    @(negedge clk); run = hold_run; din = imm; #1;
    if (op == 2'b10) begin
      chk(done === 1'b1, "R3 done", done, 1);
      chk(bus === imm, "R3 bus", bus, imm);
      m[x] = imm;
    end else if (op == 2'b00) begin
      chk(done === 1'b1, "R4 done", done, 1);
      chk(bus === m[y], "R4 bus", bus, m[y]);
      m[x] = m[y];
    end else begin
      res = op[1] ? m[x] - m[y] : m[x] + m[y];
      chk(bus === m[x] && done === 1'b0, op[1] ? "R6 step0" : "R5 step0", bus, m[x]);
      @(negedge clk); din = 8'h7F; #1;
      chk(bus === m[y] && done === 1'b0, op[1] ? "R6 step1" : "R5 step1", bus, m[y]);
      @(negedge clk); #1;
      chk(done === 1'b1, op[1] ? "R6 done" : "R5 done", done, 1);
      chk(bus === res, op[1] ? "R6 result" : "R5 result", bus, res);
      m[x] = res;
    end
    @(negedge clk); run = 0; #1;
    chk(done === 1'b0 && bus === 8'h00, hold_run ? "R2 run ignored" : "R9 idle", bus, 0);
  endtask

  task automatic read_all(input string tag);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk); run = 1; din = {2'b00, 3'(r), 3'(r)};
      @(negedge clk); run = 0; #1;
      chk(bus === m[r] && done === 1'b1, tag, bus, m[r]);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk(done === 1'b0 && bus === 8'h00, "R1 idle after reset", bus, 0);
    read_all("R1 reg cleared");
  endtask

  task automatic t_load_move;
    exec(8'b10_011_000, 8'hA5, 0);
    exec(8'b10_110_000, 8'h3C, 0);
    exec(8'b00_001_011, 8'h00, 0);
    read_all("R7 after loads/move");
  endtask

  task automatic t_arith;
    exec(8'b10_010_000, 8'hF0, 0);
    exec(8'b10_101_000, 8'h20, 0);
    exec(8'b01_010_101, 8'h00, 0);
    exec(8'b11_101_010, 8'h00, 0);
    exec(8'b11_011_011, 8'h00, 0);
    exec(8'b01_110_110, 8'h00, 0);
    read_all("R7 after arith");
  endtask

  task automatic t_run_held;
    exec(8'b01_001_110, 8'h00, 1);
    exec(8'b10_111_000, 8'h5A, 1);
    read_all("R2 state after held run");
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      logic [7:0] w = 8'($urandom);
      exec(w, 8'($urandom), 0);
    end
    read_all("R7 after random");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_load_move;
    t_arith;
    t_run_held;
    t_random;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R9 watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule